// File: doc/BRIEF.md
# Vectored Interrupt Register-Set Switcher

This block performs the entry step of a vectored interrupt. An external interrupt controller presents a request that carries a target register set, an interrupt level, a non-maskable flag and a handler address. When the block accepts the request, it takes a snapshot of the current status word and the current program counter. It then produces one cycle of write strobes. These strobes update the status word, save the old status and the return address, and load the program counter with the handler address.

The old status goes to one of two places. When the target set is 0, it goes to the exception-status register. When the target set is nonzero, it goes to that shadow set's own saved-status slot. If the target set differs from the set that was running, the saved copy is marked with a set-changed bit. No save takes place while the exception-handling bit of the status word is set. The return address is the interrupted PC plus 4.

The request side is a valid/ready stream. The controller holds `req_valid` and the request fields steady until it sees `req_ready` high at a clock edge. The block accepts one request and then drops `req_ready` for exactly one cycle, the commit cycle, during which `ack` is high. A request presented in that cycle is not taken, and the controller must keep it presented.

Top module: `irq_rset_switch`

## Requirements
- R1: After reset `req_ready` is 1 and `ack` is 0. A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `ack` is then high for exactly the following cycle, the commit cycle. `req_ready` is 0 during the commit cycle, and a request presented during the commit cycle is not accepted.
- R2: In the written status, the current-set field [17:12] equals the requested set, the level field [11:6] equals the requested level, and bit 3 equals the non-maskable flag.
- R3: In the written status, bit 4 (set interrupt enable) and bit 0 (user mode) are 0 and bit 2 (interrupt handler) is 1. Bit 1 (exception handling), bit 5 (set changed) and bits [31:24] keep the snapshot value.
- R4: If the snapshot's bit 1 is 0, the previous-set field [23:18] of the written status takes the old current-set value. If bit 1 is 1, the field keeps its snapshot value.
- R5: If bit 1 is 0 and the requested set is 0, the block writes the exception-status register with the snapshot status. In that case no saved-status slot is written.
- R6: If bit 1 is 0 and the requested set is nonzero, the block writes the saved-status slot of that set with the snapshot status. Bit 5 of the written value is forced to 1 when the requested set differs from the old current set. Otherwise the snapshot value is written unchanged. The exception-status register is not written in this case.
- R7: If bit 1 is 0, the block writes the return-address register of the requested set with the snapshot PC plus 4, modulo the PC width.
- R8: If bit 1 is 1, none of the three save strobes is raised.
- R9: In the commit cycle `pc_we` is 1 and `pc_data` equals the accepted handler address. `status_we` is 1 in the same cycle.
- R10: Outside the commit cycle every write strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Controller presents a request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_set | input | 6 | Requested register set |
| req_level | input | 6 | Requested interrupt level |
| req_nmi | input | 1 | Request is non-maskable |
| req_handler | input | PC_W | Handler address |
| cur_status | input | 32 | Current status word |
| cur_pc | input | PC_W | PC of the interrupted instruction |
| ack | output | 1 | Commit-cycle pulse to the controller |
| status_we | output | 1 | Status word write strobe |
| status_data | output | 32 | New status word |
| estatus_we | output | 1 | Exception-status register write strobe |
| estatus_data | output | 32 | Value for exception-status |
| sstat_we | output | 1 | Shadow saved-status slot write strobe |
| sstat_set | output | 6 | Shadow set addressed by the slot write |
| sstat_data | output | 32 | Value for the saved-status slot |
| sea_we | output | 1 | Shadow return-address write strobe |
| sea_set | output | 6 | Shadow set addressed by the return-address write |
| sea_data | output | PC_W | Return address |
| pc_we | output | 1 | PC write strobe |
| pc_data | output | PC_W | Next PC |

## Verification
Every result of an accepted request is due in the single cycle after the accepting edge. All strobes and data are registered, so they appear one edge after acceptance and clear at the next edge. The bench drives inputs on the falling edge and samples all outputs at the falling edge after the accepting edge. It samples again one cycle later, after presenting a different request during the commit cycle, to confirm that nothing is written and that the second request was not taken. A sweep covers every combination of old set, requested set and exception-handling bit over the low four sets, with varied levels, flags, PCs and status patterns.

// File: rtl/irq_rset_pkg.sv
package irq_rset_pkg;
  localparam int ST_W   = 32;
  localparam int RS_W   = 6;
  localparam int LVL_W  = 6;
  localparam int B_USER = 0;
  localparam int B_EXC  = 1;
  localparam int B_HND  = 2;
  localparam int B_NMI  = 3;
  localparam int B_RSIE = 4;
  localparam int B_CHG  = 5;
  localparam int F_LVL  = 6;
  localparam int F_CUR  = 12;
  localparam int F_PREV = 18;

  typedef struct packed {
    logic [RS_W-1:0]  set;
    logic [LVL_W-1:0] level;
    logic             nmi;
  } irq_req_t;
endpackage

// File: rtl/irq_status_compose.sv
module irq_status_compose
  import irq_rset_pkg::*;
(
  input  logic [ST_W-1:0] old_status,
  input  irq_req_t        req,
  output logic [ST_W-1:0] new_status
);
  always_comb begin
    new_status = old_status;
    new_status[F_CUR +: RS_W]  = req.set;
    new_status[F_LVL +: LVL_W] = req.level;
    new_status[B_NMI]  = req.nmi;
    new_status[B_RSIE] = 1'b0;
    new_status[B_USER] = 1'b0;
    new_status[B_HND]  = 1'b1;
    if (!old_status[B_EXC])
      new_status[F_PREV +: RS_W] = old_status[F_CUR +: RS_W];
  end
endmodule

// File: rtl/irq_save_route.sv
module irq_save_route
  import irq_rset_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [ST_W-1:0] old_status,
  input  logic [RS_W-1:0] tgt_set,
  input  logic [PC_W-1:0] old_pc,
  output logic            es_en,
  output logic            ss_en,
  output logic [ST_W-1:0] ss_val,
  output logic            ea_en,
  output logic [PC_W-1:0] ea_val
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);
  logic save_ok;
  logic to_base;
  assign save_ok = !old_status[B_EXC];
  assign to_base = (tgt_set == '0);

  always_comb begin
    es_en  = save_ok && to_base;
    ss_en  = save_ok && !to_base;
    ss_val = old_status;
    if (tgt_set != old_status[F_CUR +: RS_W])
      ss_val[B_CHG] = 1'b1;
    ea_en  = save_ok;
    ea_val = old_pc + STEP;
  end
endmodule

// File: rtl/irq_rset_switch.sv
module irq_rset_switch
  import irq_rset_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [RS_W-1:0]         req_set,
  input  logic [LVL_W-1:0]        req_level,
  input  logic                    req_nmi,
  input  logic [PC_W-1:0]         req_handler,
  input  logic [ST_W-1:0]         cur_status,
  input  logic [PC_W-1:0]         cur_pc,
  output logic                    ack,
  output logic                    status_we,
  output logic [ST_W-1:0]         status_data,
  output logic                    estatus_we,
  output logic [ST_W-1:0]         estatus_data,
  output logic                    sstat_we,
  output logic [RS_W-1:0]         sstat_set,
  output logic [ST_W-1:0]         sstat_data,
  output logic                    sea_we,
  output logic [RS_W-1:0]         sea_set,
  output logic [PC_W-1:0]         sea_data,
  output logic                    pc_we,
  output logic [PC_W-1:0]         pc_data
);
  irq_req_t        req_w;
  logic            take;
  logic [ST_W-1:0] nxt_status;
  logic            es_en, ss_en, ea_en;
  logic [ST_W-1:0] ss_val;
  logic [PC_W-1:0] ea_val;
  logic            commit_q;

  assign req_w     = '{set: req_set, level: req_level, nmi: req_nmi};
  assign req_ready = !commit_q;
  assign take      = req_valid && req_ready;
  assign ack       = commit_q;

  irq_status_compose u_compose (
    .old_status (cur_status),
    .req        (req_w),
    .new_status (nxt_status)
  );

  irq_save_route #(.PC_W(PC_W)) u_route (
    .old_status (cur_status),
    .tgt_set    (req_set),
    .old_pc     (cur_pc),
    .es_en      (es_en),
    .ss_en      (ss_en),
    .ss_val     (ss_val),
    .ea_en      (ea_en),
    .ea_val     (ea_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q   <= 1'b0;
      status_we  <= 1'b0;
      estatus_we <= 1'b0;
      sstat_we   <= 1'b0;
      sea_we     <= 1'b0;
      pc_we      <= 1'b0;
    end else begin
      commit_q   <= take;
      status_we  <= take;
      pc_we      <= take;
      estatus_we <= take && es_en;
      sstat_we   <= take && ss_en;
      sea_we     <= take && ea_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_data  <= '0;
      estatus_data <= '0;
      sstat_set    <= '0;
      sstat_data   <= '0;
      sea_set      <= '0;
      sea_data     <= '0;
      pc_data      <= '0;
    end else if (take) begin
      status_data  <= nxt_status;
      estatus_data <= cur_status;
      sstat_set    <= req_set;
      sstat_data   <= ss_val;
      sea_set      <= req_set;
      sea_data     <= ea_val;
      pc_data      <= req_handler;
    end
  end
endmodule

// File: rtl/irq_rset_switch_chk.sv
module irq_rset_switch_chk
  import irq_rset_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [PC_W-1:0] req_handler,
  input logic [ST_W-1:0] cur_status,
  input logic [PC_W-1:0] cur_pc,
  input logic            ack,
  input logic            status_we,
  input logic            estatus_we,
  input logic            sstat_we,
  input logic            sea_we,
  input logic [PC_W-1:0] sea_data,
  input logic            pc_we,
  input logic [PC_W-1:0] pc_data
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R1
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !req_ready); // R1
  AST_HANDLER_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pc_we && status_we && pc_data == $past(req_handler))); // R9
  AST_SAVE_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    !(estatus_we && sstat_we)); // R5
  AST_EH_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cur_status[B_EXC]) |=> (!estatus_we && !sstat_we && !sea_we)); // R8
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cur_status[B_EXC]) |=> (sea_we && sea_data == $past(cur_pc) + PC_W'(4))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> !(status_we || estatus_we || sstat_we || sea_we || pc_we)); // R10
endmodule

bind irq_rset_switch irq_rset_switch_chk #(.PC_W(PC_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
  .req_handler (req_handler), .cur_status (cur_status), .cur_pc (cur_pc),
  .ack (ack), .status_we (status_we), .estatus_we (estatus_we),
  .sstat_we (sstat_we), .sea_we (sea_we), .sea_data (sea_data),
  .pc_we (pc_we), .pc_data (pc_data)
);

// File: tb/irq_rset_switch_tb_top.sv
module irq_rset_switch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_set = '0;
  logic [5:0]  req_level = '0;
  logic        req_nmi = 1'b0;
  logic [31:0] req_handler = '0;
  logic [31:0] cur_status = '0;
  logic [31:0] cur_pc = '0;
  logic        ack, status_we, estatus_we, sstat_we, sea_we, pc_we;
  logic [31:0] status_data, estatus_data, sstat_data, sea_data, pc_data;
  logic [5:0]  sstat_set, sea_set;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_rset_switch #(.PC_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_level(req_level), .req_nmi(req_nmi),
    .req_handler(req_handler), .cur_status(cur_status), .cur_pc(cur_pc),
    .ack(ack), .status_we(status_we), .status_data(status_data),
    .estatus_we(estatus_we), .estatus_data(estatus_data),
    .sstat_we(sstat_we), .sstat_set(sstat_set), .sstat_data(sstat_data),
    .sea_we(sea_we), .sea_set(sea_set), .sea_data(sea_data),
    .pc_we(pc_we), .pc_data(pc_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset ack", {31'd0, ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      automatic logic       eh   = i[0];
      automatic logic [5:0] ocur = 6'(i[2:1]);
      automatic logic [5:0] tset = 6'(i[4:3]);
      automatic logic [5:0] lvl  = i[5] ? 6'd63 : 6'(i * 5);
      automatic logic       nmi  = i[1] ^ i[3];
      automatic logic [31:0] old_st, pc, hnd, exp_st, exp_ss;
      old_st = 32'h5A3C_0F11 ^ (32'(i) * 32'h0101_0101);
      old_st[1] = eh;
      old_st[17:12] = ocur;
      pc  = (i == 7) ? 32'hFFFF_FFFC : 32'h0000_1000 + 32'(i * 8);
      hnd = 32'h8000_0000 | 32'(i * 16);
      // expected status: fields written, clears and sets arithmetically
      exp_st = (old_st & ~32'h0003_FFD9) | (32'(tset) << 12) | (32'(lvl) << 6)
               | (32'(nmi) << 3) | 32'h4;
      if (!eh) exp_st = (exp_st & ~32'h00FC_0000) | (32'(ocur) << 18);
      exp_ss = (tset != ocur) ? (old_st | 32'h20) : old_st;
      req_valid = 1'b1; req_set = tset; req_level = lvl; req_nmi = nmi;
      req_handler = hnd; cur_status = old_st; cur_pc = pc;
      @(negedge clk);
      chk("R1 ack", {31'd0, ack}, 32'd1);
      chk("R1 ready low", {31'd0, req_ready}, 32'd0);
      chk("R9 pc_we", {30'd0, pc_we, status_we}, 32'd3);
      chk("R9 pc_data", pc_data, hnd);
      chk("R2 R3 R4 status", status_data, exp_st);
      chk("R5 R8 estatus_we", {31'd0, estatus_we}, 32'(!eh && tset == 0));
      chk("R6 R8 sstat_we", {31'd0, sstat_we}, 32'(!eh && tset != 0));
      chk("R7 R8 sea_we", {31'd0, sea_we}, 32'(!eh));
      if (!eh && tset == 0) chk("R5 estatus data", estatus_data, old_st);
      if (!eh && tset != 0) begin
        chk("R6 slot set", 32'(sstat_set), 32'(tset));
        chk("R6 slot data", sstat_data, exp_ss);
      end
      if (!eh) begin
        chk("R7 ea set", 32'(sea_set), 32'(tset));
        chk("R7 ea data", sea_data, pc + 32'd4);
      end
      // different request during commit must not be taken
      req_handler = 32'hDEAD_0000; req_set = 6'd9;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 commit request ignored", {31'd0, ack}, 32'd0);
      chk("R10 strobes idle", {27'd0, status_we, estatus_we, sstat_we, sea_we, pc_we}, 32'd0);
      chk("R1 ready back", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule